// File: doc/BRIEF.md
# Register Result Status Rename Table

This block keeps, for every architectural floating-point register, the tag of the reservation station that will produce its next value, together with the register's committed contents. A zero tag means that no instruction in flight targets the register. When an instruction issues, the table looks up both of its source registers. For each source it returns either the register value with a zero tag, or the tag of the pending producer. On the same clock edge it records the issuing station's tag against the destination register.

The table also watches the result broadcast bus. A broadcast carries a data word and the tag of the station that produced it. Every register whose pending tag equals the broadcast tag takes the data and becomes blank again. A register that has been renamed to a newer producer keeps waiting for that newer tag.

Because a newer issue simply overwrites the destination entry, write-after-write and write-after-read ordering need no stall. The reservation stations, bus arbitration and decode sit outside this block.

Top module: `rename_table`

## Requirements
- R1: After a synchronous active-low reset, every register reads back with tag 0 and value 0.
- R2: With no matching broadcast, a source read of a register returns that register's stored value on the value output and its pending tag on the tag output, where tag 0 means the value is valid.
- R3: When `iss_valid` is high, the destination register's tag becomes `iss_tag` from the next cycle onward. A second issue to the same register overwrites the first tag without any stall. A source read in the issue cycle still sees the mapping held before that issue.
- R4: When `bus_valid` is high, `bus_tag` is nonzero and `bus_tag` equals a register's pending tag, that register's value becomes `bus_data` in the next cycle.
- R5: A register that matches a broadcast, and that is not renamed in the same cycle, reads with tag 0 from the next cycle.
- R6: If a register matches a broadcast in the same cycle that it is renamed as a destination, the new issue tag is kept and the broadcast data is still written to the value.
- R7: A source read of a register whose pending tag matches a broadcast in that same cycle returns `bus_data` with tag 0.
- R8: After a register has been renamed to a newer tag, a broadcast carrying the older tag changes neither its tag nor its value.
- R9: A broadcast with `bus_valid` low or with `bus_tag` equal to 0 changes nothing. A broadcast whose tag is pending on several registers updates all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_src_a | input | 2 | First source register index |
| iss_src_b | input | 2 | Second source register index |
| iss_dst | input | 2 | Destination register index |
| iss_tag | input | 4 | Tag of the issuing station, nonzero |
| bus_valid | input | 1 | Result broadcast present |
| bus_tag | input | 4 | Tag of the producing station |
| bus_data | input | 64 | Broadcast result data |
| src_a_value | output | 64 | Value of source A, or of the bypassed broadcast |
| src_a_tag | output | 4 | Pending producer of source A, 0 if ready |
| src_b_value | output | 64 | Value of source B, or of the bypassed broadcast |
| src_b_tag | output | 4 | Pending producer of source B, 0 if ready |

## Verification
The hardest case to reach is the one where a register is renamed while a broadcast carries the tag it currently holds. In that case the value must change and the tag must not. A stale older tag arriving after a rename is nearly as hard. The stimulus reaches both through directed sequences: it issues to a register, then in the next cycle broadcasts the pending tag while issuing to the same register again. In a separate sequence it issues twice to one register before broadcasting the first tag. A randomized phase then draws broadcast tags mostly from the tags currently pending in the reference model, so that matches, bypasses and rename collisions recur often.

// File: rtl/rt_pkg.sv
// Package rt_pkg
// Holds the default geometry shared by the rename table and its bench.
// Assumes tag value 0 is reserved to mean "no pending producer".
package rt_pkg;
    localparam int DEF_NUM_REGS = 4;
    localparam int DEF_DATA_W   = 64;
    localparam int DEF_TAG_W    = 4;
endpackage

// File: rtl/rt_entry.sv
// Module rt_entry
// One register's storage: pending producer tag plus committed value.
// Assumes new_tag_i is nonzero whenever rename_i is high.
module rt_entry #(
    parameter int DATA_W = 64,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rename_i,
    input  logic [TAG_W-1:0]  new_tag_i,
    input  logic              bus_valid_i,
    input  logic [TAG_W-1:0]  bus_tag_i,
    input  logic [DATA_W-1:0] bus_data_i,
    output logic [TAG_W-1:0]  tag_o,
    output logic [DATA_W-1:0] value_o,
    output logic              hit_o
);
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] value_q;
    logic              hit;

    // Detect a broadcast aimed at this entry's pending producer.
    always_comb begin
        hit = bus_valid_i && (bus_tag_i != '0) && (tag_q == bus_tag_i);
    end

    // Update the tag: a rename wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        tag_q <= '0;
        else if (rename_i) tag_q <= new_tag_i;
        else if (hit)      tag_q <= '0;
    end

    // Capture broadcast data into the register value.
    always_ff @(posedge clk) begin
        if (!rst_n)   value_q <= '0;
        else if (hit) value_q <= bus_data_i;
    end

    assign tag_o   = tag_q;
    assign value_o = value_q;
    assign hit_o   = hit;

    AST_RENAME_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        rename_i |=> (tag_q == $past(new_tag_i))); // R3
    AST_MATCH_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_i && bus_tag_i != '0 && tag_o == bus_tag_i) |=> (value_q == $past(bus_data_i))); // R4
    AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_i && bus_tag_i != '0 && tag_o == bus_tag_i && !rename_i) |=> (tag_q == '0)); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rename_i && !(bus_valid_i && bus_tag_i != '0 && tag_o == bus_tag_i))
        |=> ($stable(tag_q) && $stable(value_q))); // R8
endmodule

// File: rtl/rt_read_port.sv
// Module rt_read_port
// Combinational source lookup with bypass of a same-cycle matching broadcast.
// Assumes the per-entry hit flags are already qualified by valid and nonzero tag.
module rt_read_port #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 64,
    parameter int TAG_W    = 4,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic [IDX_W-1:0]                 idx_i,
    input  logic [NUM_REGS-1:0][TAG_W-1:0]   tags_i,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  values_i,
    input  logic [NUM_REGS-1:0]              hits_i,
    input  logic [DATA_W-1:0]                bus_data_i,
    output logic [DATA_W-1:0]                value_o,
    output logic [TAG_W-1:0]                 tag_o
);
    // Select the entry, forwarding the broadcast when it resolves the entry now.
    always_comb begin
        if (hits_i[idx_i]) begin
            value_o = bus_data_i;
            tag_o   = '0;
        end else begin
            value_o = values_i[idx_i];
            tag_o   = tags_i[idx_i];
        end
    end
endmodule

// File: rtl/rename_table.sv
// Module rename_table
// Register result status table: per-register producer tags, two source
// lookups at issue, destination rename, and result bus snooping.
// Assumes iss_tag is nonzero when iss_valid is high.
module rename_table #(
    parameter int NUM_REGS = rt_pkg::DEF_NUM_REGS,
    parameter int DATA_W   = rt_pkg::DEF_DATA_W,
    parameter int TAG_W    = rt_pkg::DEF_TAG_W,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [IDX_W-1:0]  iss_src_a,
    input  logic [IDX_W-1:0]  iss_src_b,
    input  logic [IDX_W-1:0]  iss_dst,
    input  logic [TAG_W-1:0]  iss_tag,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    output logic [DATA_W-1:0] src_a_value,
    output logic [TAG_W-1:0]  src_a_tag,
    output logic [DATA_W-1:0] src_b_value,
    output logic [TAG_W-1:0]  src_b_tag
);
    logic [NUM_REGS-1:0][TAG_W-1:0]  tags;
    logic [NUM_REGS-1:0][DATA_W-1:0] values;
    logic [NUM_REGS-1:0]             hits;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        rt_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_entry (
            .clk         (clk),
            .rst_n       (rst_n),
            .rename_i    (iss_valid && (iss_dst == IDX_W'(g))),
            .new_tag_i   (iss_tag),
            .bus_valid_i (bus_valid),
            .bus_tag_i   (bus_tag),
            .bus_data_i  (bus_data),
            .tag_o       (tags[g]),
            .value_o     (values[g]),
            .hit_o       (hits[g])
        );
    end

    rt_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_read_a (
        .idx_i (iss_src_a), .tags_i (tags), .values_i (values), .hits_i (hits),
        .bus_data_i (bus_data), .value_o (src_a_value), .tag_o (src_a_tag)
    );

    rt_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_read_b (
        .idx_i (iss_src_b), .tags_i (tags), .values_i (values), .hits_i (hits),
        .bus_data_i (bus_data), .value_o (src_b_value), .tag_o (src_b_tag)
    );

    AST_ISSUE_TAG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (iss_tag != '0)); // R3
    AST_BYPASS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_tag != '0 && tags[iss_src_a] == bus_tag)
        |-> (src_a_tag == '0 && src_a_value == bus_data)); // R7
    AST_NULL_BUS_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (!iss_valid && (!bus_valid || bus_tag == '0)) |=> $stable(tags)); // R9
endmodule

// File: tb/rename_table_tb.sv
// Bench for rename_table: behavioural reference model compared every cycle.
module rename_table_tb;
    localparam int NR = 4;
    localparam int DW = 64;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          iss_valid;
    logic [1:0]    iss_src_a, iss_src_b, iss_dst;
    logic [TW-1:0] iss_tag;
    logic          bus_valid;
    logic [TW-1:0] bus_tag;
    logic [DW-1:0] bus_data;
    logic [DW-1:0] src_a_value, src_b_value;
    logic [TW-1:0] src_a_tag, src_b_tag;

    int            m_tag [NR];
    logic [DW-1:0] m_val [NR];
    int            checks = 0;
    int            fails  = 0;

    always #2 clk = ~clk;

    rename_table u_dut (
        .clk (clk), .rst_n (rst_n),
        .iss_valid (iss_valid), .iss_src_a (iss_src_a), .iss_src_b (iss_src_b),
        .iss_dst (iss_dst), .iss_tag (iss_tag),
        .bus_valid (bus_valid), .bus_tag (bus_tag), .bus_data (bus_data),
        .src_a_value (src_a_value), .src_a_tag (src_a_tag),
        .src_b_value (src_b_value), .src_b_tag (src_b_tag)
    );

    function automatic bit m_hit(int r);
        return bus_valid && bus_tag != 0 && m_tag[r] != 0 && m_tag[r] == int'(bus_tag);
    endfunction

    task automatic cmp_port(string req, int r, logic [DW-1:0] av, logic [TW-1:0] at);
        logic [DW-1:0] ev;
        int            et;
        if (m_hit(r)) begin ev = bus_data; et = 0; end
        else          begin ev = m_val[r]; et = m_tag[r]; end
        checks++;
        if (av !== ev || int'(at) != et) begin
            fails++;
            $display("FAIL %s reg%0d: got value %h tag %0d, expected value %h tag %0d",
                     req, r, av, at, ev, et);
        end
    endtask

    // Drive one cycle, compare both read ports, then advance the model at the edge.
    task automatic step(string req, bit iv, int sa, int sb, int d, int t,
                        bit bv, int bt, logic [DW-1:0] bd);
        iss_valid = iv; iss_src_a = 2'(sa); iss_src_b = 2'(sb);
        iss_dst = 2'(d); iss_tag = TW'(t);
        bus_valid = bv; bus_tag = TW'(bt); bus_data = bd;
        #1;
        cmp_port(req, sa, src_a_value, src_a_tag);
        cmp_port(req, sb, src_b_value, src_b_tag);
        @(posedge clk);
        for (int i = 0; i < NR; i++) begin
            bit h;
            h = m_hit(i);
            if (h) m_val[i] = bd;
            if (iv && d == i) m_tag[i] = t;
            else if (h)       m_tag[i] = 0;
        end
        @(negedge clk);
    endtask

    task automatic look(string req, int sa, int sb);
        step(req, 1'b0, sa, sb, 0, 1, 1'b0, 0, '0);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NR; i++) begin m_tag[i] = 0; m_val[i] = '0; end
        rst_n = 1'b0;
        iss_valid = 0; iss_src_a = 0; iss_src_b = 0; iss_dst = 0; iss_tag = 1;
        bus_valid = 0; bus_tag = 0; bus_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state on every register
        look("R1", 0, 1);
        look("R1", 2, 3);
        // R3: rename reg1 to tag 5; same-cycle read sees the old blank mapping
        step("R3", 1'b1, 1, 1, 1, 5, 1'b0, 0, '0);
        look("R3", 1, 0);
        // R7 then R4/R5: broadcast tag 5 with bypass, then settled value
        step("R7", 1'b0, 1, 2, 0, 1, 1'b1, 5, 64'hAAAA_0000_1111_2222);
        look("R4", 1, 1);
        look("R5", 1, 2);
        // R2: blank register read returns its stored value
        look("R2", 1, 3);
        // R8: WAW on reg2, then broadcast of the older tag is ignored
        step("R3", 1'b1, 2, 0, 2, 3, 1'b0, 0, '0);
        step("R3", 1'b1, 2, 0, 2, 7, 1'b0, 0, '0);
        step("R8", 1'b0, 2, 1, 0, 1, 1'b1, 3, 64'hDEAD_BEEF_0000_0003);
        look("R8", 2, 2);
        step("R5", 1'b0, 2, 0, 0, 1, 1'b1, 7, 64'h0000_0000_0000_0777);
        look("R4", 2, 0);
        // R6: rename collides with a matching broadcast on reg0
        step("R6", 1'b1, 0, 3, 0, 4, 1'b0, 0, '0);
        step("R6", 1'b1, 0, 0, 0, 9, 1'b1, 4, 64'h1234_5678_9ABC_DEF0);
        look("R6", 0, 0);
        // R9: invalid and zero-tag broadcasts are inert; shared tag updates both
        step("R9", 1'b1, 1, 3, 1, 6, 1'b0, 0, '0);
        step("R9", 1'b1, 3, 1, 3, 6, 1'b0, 6, 64'hFFFF);
        step("R9", 1'b0, 1, 3, 0, 1, 1'b1, 0, 64'h5555);
        look("R9", 1, 3);
        step("R9", 1'b0, 0, 1, 0, 1, 1'b1, 6, 64'h6666_6666_6666_6666);
        look("R9", 1, 3);
        step("R5", 1'b0, 0, 0, 0, 1, 1'b1, 9, 64'h9);
        // Randomized traffic, broadcast tags biased toward pending ones
        for (int n = 0; n < 400; n++) begin
            int            pick;
            int            btag;
            logic [DW-1:0] bd;
            pick = $urandom_range(0, NR - 1);
            btag = ($urandom_range(0, 3) != 0) ? m_tag[pick] : $urandom_range(0, 15);
            bd   = {$urandom(), $urandom()};
            step("RAND", 1'($urandom_range(0, 1)), $urandom_range(0, 3), $urandom_range(0, 3),
                 $urandom_range(0, 3), $urandom_range(1, 15),
                 1'($urandom_range(0, 3) != 0), btag, bd);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule